// File: doc/BRIEF.md
# DMA request line allocator

This block hands out a small pool of external DMA request lines to USB endpoint channels. Each line has a 5-bit slot in one packed map word, which records the owning endpoint number and whether that channel transmits. An allocate command binds the lowest free line to the requesting endpoint and direction. A release command frees that binding again. Every command returns a grant or failure response, together with the line index. The map word is driven out continuously, so a neighbouring request router can decode it.

The block also keeps an interrupt mask with one bit per endpoint and direction. A successful allocation unmasks the channel's bit. A successful release masks it again and pulses the matching bit of an interrupt-clear vector for one cycle.

A shared-mode input folds the pool down to line 0 alone. In that mode only one endpoint may own the line at a time, and a release is honoured only when it comes from the endpoint that holds the line.

Top module: `dmareq_alloc`

## Requirements
- R1: After reset the map word is 0, the interrupt mask is 0x7FFFFFFF, the clear vector is 0 and no response is valid.
- R2: Line i occupies map bits [5i+4:5i]. Bits [5i+3:5i] hold the endpoint number, and bit 5i+4 is 1 for a transmit channel and 0 for a receive channel.
- R3: A command sampled on a clock edge updates the state on that edge, and its response is valid for exactly the following cycle. A granted allocation in normal mode returns the lowest-indexed line whose endpoint bits are zero.
- R4: Only lines 0 to 4 are ever granted. When those five lines are all taken, an allocation fails and leaves the map unchanged. Map bits [29:25] stay 0.
- R5: A command for endpoint 0, allocate or release, in either mode, fails and changes nothing.
- R6: In normal mode a release frees the lowest line whose field equals the requested endpoint and direction, reports that line, and clears all 5 bits of its field. If no line matches, the response has the error flag set and nothing changes.
- R7: In shared mode an allocation fails when the map word is nonzero. Otherwise it writes the endpoint and direction into line 0 and grants line 0.
- R8: In shared mode a release whose endpoint differs from line 0's endpoint bits sets the error flag and changes nothing. A matching release sets the whole map word to 0.
- R9: A channel's mask bit is at position endpoint for transmit and position endpoint+15 for receive. A granted allocation clears that bit, and a successful release sets it.
- R10: A successful release pulses the same bit position of the clear vector during its response cycle. At all other times the clear vector is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shared_mode | input | 1 | 1 restricts allocation to line 0 with single ownership |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_release | input | 1 | 0 for allocate, 1 for release |
| cmd_ep | input | 4 | Endpoint number |
| cmd_tx | input | 1 | 1 for transmit, 0 for receive |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_ok | output | 1 | Command succeeded |
| rsp_err | output | 1 | Release did not match any owner |
| rsp_line | output | 3 | Granted or freed line index |
| map_word | output | 30 | Packed line map |
| int_mask | output | 31 | Interrupt mask |
| int_clr | output | 31 | One-cycle interrupt clear pulses |

## Verification
The bench builds the block with its default parameters: six lines, five of them grantable, 4-bit endpoints and a 31-bit mask. With these values all fifteen nonzero endpoints can be requested, so a full pool, the rx bit at the top of the mask (endpoint 15 at bit 30) and the line that is never granted are all exercised. A seeded random run in each mode is compared against a bench model. The mode is switched while lines are still owned, so the shared-mode busy check also meets maps that normal mode filled.

// File: rtl/dmareq_alloc.sv
module dmareq_alloc #(
  parameter int NUM_LINES = 6,
  parameter int USABLE    = 5,
  parameter int EP_W      = 4,
  parameter int MASK_W    = 31,
  parameter int RX_OFS    = 15
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           shared_mode,
  input  logic                           cmd_valid,
  input  logic                           cmd_release,
  input  logic [EP_W-1:0]                cmd_ep,
  input  logic                           cmd_tx,
  output logic                           rsp_valid,
  output logic                           rsp_ok,
  output logic                           rsp_err,
  output logic [$clog2(NUM_LINES)-1:0]   rsp_line,
  output logic [(EP_W+1)*NUM_LINES-1:0]  map_word,
  output logic [MASK_W-1:0]              int_mask,
  output logic [MASK_W-1:0]              int_clr
);
  localparam int FW    = EP_W + 1;
  localparam int MAP_W = FW * NUM_LINES;
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int MI_W  = $clog2(MASK_W);

  logic [MI_W-1:0]  msk_idx;
  logic [FW-1:0]    want;
  logic             free_found, hit_found;
  logic [IDX_W-1:0] free_idx, hit_idx;
  logic             ep_zero;

  assign msk_idx = cmd_tx ? MI_W'(cmd_ep) : MI_W'(cmd_ep) + MI_W'(RX_OFS);
  assign want    = {cmd_tx, cmd_ep};
  assign ep_zero = (cmd_ep == '0);

  always_comb begin
    free_found = 1'b0;
    hit_found  = 1'b0;
    free_idx   = '0;
    hit_idx    = '0;
    for (int i = USABLE - 1; i >= 0; i--) begin
      if (map_word[i*FW +: EP_W] == '0) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
      if (map_word[i*FW +: FW] == want) begin
        hit_found = 1'b1;
        hit_idx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_word  <= '0;
      int_mask  <= {MASK_W{1'b1}};
      int_clr   <= '0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_line  <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_ok    <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_line  <= '0;
      int_clr   <= '0;
      if (cmd_valid && !ep_zero) begin
        if (!cmd_release) begin
          if (shared_mode) begin
            if (map_word == '0) begin
              map_word[FW-1:0]  <= want;
              int_mask[msk_idx] <= 1'b0;
              rsp_ok            <= 1'b1;
            end
          end else if (free_found) begin
            map_word[free_idx*FW +: FW] <= want;
            int_mask[msk_idx]           <= 1'b0;
            rsp_ok                      <= 1'b1;
            rsp_line                    <= free_idx;
          end
        end else begin
          if (shared_mode) begin
            if (map_word[EP_W-1:0] == cmd_ep) begin
              map_word          <= '0;
              int_mask[msk_idx] <= 1'b1;
              int_clr[msk_idx]  <= 1'b1;
              rsp_ok            <= 1'b1;
            end else begin
              rsp_err <= 1'b1;
            end
          end else if (hit_found) begin
            map_word[hit_idx*FW +: FW] <= '0;
            int_mask[msk_idx]          <= 1'b1;
            int_clr[msk_idx]           <= 1'b1;
            rsp_ok                     <= 1'b1;
            rsp_line                   <= hit_idx;
          end else begin
            rsp_err <= 1'b1;
          end
        end
      end else if (cmd_valid && cmd_release) begin
        rsp_err <= 1'b1;
      end
    end
  end

  // R3: a response appears only in the cycle after a command
  a_r3_rsp_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid));

  // R4: lines above the usable range are never written
  a_r4_top_lines_idle: assert property (@(posedge clk) disable iff (!rst_n)
    map_word[MAP_W-1:USABLE*FW] == '0);

  // R4: a granted line index is inside the usable range
  a_r4_line_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> (int'(rsp_line) < USABLE));

  // R5: endpoint 0 never succeeds and never moves the map
  a_r5_ep0_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && ep_zero) |=> (!rsp_ok && $stable(map_word)));

  // R9: a successful release leaves the channel masked
  a_r9_release_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_release && !ep_zero) |=> (rsp_ok |-> int_mask[$past(msk_idx)]));

  // R10: clear pulses only accompany a successful response
  a_r10_clr_with_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clr != '0) |-> (rsp_valid && rsp_ok && $onehot0(int_clr)));

  // R8: a shared-mode owner mismatch leaves the map untouched
  a_r8_mismatch_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $stable(map_word));
endmodule

// File: tb/dmareq_alloc_bench.sv
module dmareq_alloc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shared_mode = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_release = 1'b0;
  logic [3:0]  cmd_ep = '0;
  logic        cmd_tx = 1'b0;
  logic        rsp_valid, rsp_ok, rsp_err;
  logic [2:0]  rsp_line;
  logic [29:0] map_word;
  logic [30:0] int_mask, int_clr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [29:0] m_map;
  logic [30:0] m_mask;

  always #4 clk = ~clk;

  dmareq_alloc u_dmareq_alloc (
    .clk(clk), .rst_n(rst_n), .shared_mode(shared_mode),
    .cmd_valid(cmd_valid), .cmd_release(cmd_release), .cmd_ep(cmd_ep), .cmd_tx(cmd_tx),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err), .rsp_line(rsp_line),
    .map_word(map_word), .int_mask(int_mask), .int_clr(int_clr)
  );

  task automatic check(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int mbit(input logic [3:0] ep, input bit tx);
    return tx ? int'(ep) : int'(ep) + 15;
  endfunction

  task automatic do_cmd(input bit rel, input logic [3:0] ep, input bit tx, input string tag);
    bit e_ok = 0, e_err = 0;
    int e_line = 0;
    logic [30:0] e_clr = '0;
    if (ep != 0) begin
      if (!rel) begin
        if (shared_mode) begin
          if (m_map == 0) begin m_map[4:0] = {tx, ep}; e_ok = 1; end
        end else begin
          for (int i = 0; i < 5; i++)
            if (!e_ok && m_map[i*5 +: 4] == 0) begin
              m_map[i*5 +: 5] = {tx, ep}; e_ok = 1; e_line = i;
            end
        end
        if (e_ok) m_mask[mbit(ep, tx)] = 1'b0;
      end else begin
        if (shared_mode) begin
          if (m_map[3:0] == ep) begin m_map = '0; e_ok = 1; end
        end else begin
          for (int i = 0; i < 5; i++)
            if (!e_ok && m_map[i*5 +: 5] == {tx, ep}) begin
              m_map[i*5 +: 5] = '0; e_ok = 1; e_line = i;
            end
        end
        if (e_ok) begin m_mask[mbit(ep, tx)] = 1'b1; e_clr[mbit(ep, tx)] = 1'b1; end
        else e_err = 1;
      end
    end else if (rel) e_err = 1;
    cmd_release = rel; cmd_ep = ep; cmd_tx = tx; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(rsp_valid === 1'b1, {tag, " R3 valid"}, 32'(rsp_valid), 1);
    check(rsp_ok === e_ok, {tag, " ok"}, 32'(rsp_ok), 32'(e_ok));
    check(rsp_err === e_err, {tag, " err"}, 32'(rsp_err), 32'(e_err));
    if (e_ok) check(int'(rsp_line) == e_line, {tag, " R3 line"}, 32'(rsp_line), 32'(e_line));
    check(map_word === m_map, {tag, " R2 map"}, 32'(map_word), 32'(m_map));
    check(int_mask === m_mask, {tag, " R9 mask"}, 32'(int_mask), 32'(m_mask));
    check(int_clr === e_clr, {tag, " R10 clr"}, 32'(int_clr), 32'(e_clr));
    @(negedge clk);
    check(rsp_valid === 1'b0 && int_clr === '0, {tag, " R3/R10 one-cycle"}, 32'(rsp_valid), 0);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_map = '0;
    m_mask = 31'h7FFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(map_word === '0, "R1 map", 32'(map_word), 0);
    check(int_mask === 31'h7FFF_FFFF, "R1 mask", 32'(int_mask), 32'h7FFF_FFFF);
    check(int_clr === '0 && rsp_valid === 1'b0, "R1 idle", 32'(rsp_valid), 0);

    do_cmd(0, 4'd3, 1, "R3 first");
    check(map_word[4:0] === 5'h13, "R2 tx field", 32'(map_word[4:0]), 32'h13);
    do_cmd(0, 4'd15, 0, "R3 second");
    check(int_mask[30] === 1'b0, "R9 rx ep15 bit30", 32'(int_mask[30]), 0);
    do_cmd(0, 4'd7, 1, "R3 third");
    do_cmd(0, 4'd9, 0, "R3 fourth");
    do_cmd(0, 4'd2, 1, "R3 fifth");
    do_cmd(0, 4'd4, 1, "R4 pool full");
    check(map_word[29:25] === '0, "R4 line5 idle", 32'(map_word[29:25]), 0);
    do_cmd(1, 4'd15, 1, "R6 wrong dir");
    do_cmd(1, 4'd15, 0, "R6 release mid");
    check(map_word[9:5] === '0, "R6 field cleared", 32'(map_word[9:5]), 0);
    do_cmd(0, 4'd11, 0, "R3 reuse hole");
    do_cmd(0, 4'd0, 1, "R5 ep0 alloc");
    do_cmd(1, 4'd0, 0, "R5 ep0 release");

    for (int i = 0; i < 5; i++) do_cmd(1, m_map[i*5 +: 4], m_map[i*5+4], "R6 drain");
    shared_mode = 1'b1;
    do_cmd(0, 4'd6, 0, "R7 shared grant");
    do_cmd(0, 4'd8, 1, "R7 shared busy");
    do_cmd(1, 4'd8, 1, "R8 wrong owner");
    do_cmd(1, 4'd6, 0, "R8 owner release");
    do_cmd(0, 4'd5, 1, "R7 regrant");
    do_cmd(1, 4'd5, 1, "R8 release");

    shared_mode = 1'b0;
    for (int n = 0; n < 400; n++) begin
      if (n == 250) shared_mode = 1'b1;
      do_cmd($urandom_range(0, 1), 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), "R6/R8 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule